// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a single processor-side request port to an asynchronous dynamic RAM of 2M x 8 organisation, whose cells form 4096 rows of 4096 bits. A request carries a 21-bit byte address, a write flag and one data byte. The controller splits the address into a 12-bit row and a 9-bit column. It sends both halves one after the other over one shared 12-pin address bus. The device latches them on the falling edges of two active-low strobes, first the row strobe and then the column strobe.

The lengths of the address setup, strobe-low and precharge phases are parameters counted in clock cycles. Because the cells lose their charge, an internal timer marks a refresh as due once per `REF_INTERVAL` cycles. A refresh is a row-only cycle, with no column phase, on the row that a wrapping refresh counter supplies. A refresh never interrupts an access. A refresh that falls due during an access waits until the access ends and then goes ahead of any waiting request. Requests are accepted with a valid/ready handshake, and each one returns a single-cycle `done` pulse together with the read data.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, both strobes and the write line are high, the data drivers are off, `done` is low and `req_ready` is high.
- R2: The row placed on the bus at the fall of the row strobe equals request address bits [20:9]. The value placed on the bus at the fall of the column strobe equals bits [8:0] on pins [8:0], with pins [11:9] at zero.
- R3: The row strobe falls `T_ADDR` cycles after a request is accepted. The column strobe falls `T_ADDR + T_STROBE` cycles after the row strobe. The column strobe is only ever low while the row strobe is low, and the bus is stable in the cycle before either strobe falls.
- R4: `done` is a one-cycle pulse, asserted `2*T_ADDR + 2*T_STROBE` cycles after acceptance, in the cycle in which the column strobe has just risen. For a read, `rdata` then holds the byte the device drove while the column strobe was low.
- R5: For a write, the write line is low and the data drivers carry the request byte while the column strobe falls. For a read, the write line stays high. The drivers are never on while the write line is high.
- R6: After the row strobe rises, it stays high for at least `T_PRE` cycles before it falls again.
- R7: One refresh per `REF_INTERVAL` cycles is performed as a row strobe low pulse with the column strobe held high. The rows come from a counter that starts at 0 after reset and steps by one, wrapping modulo 4096.
- R8: A refresh that falls due during an access waits until that access completes and then runs before the next request is accepted. `req_ready` is low while a refresh is pending or in progress. Refresh spacing therefore stays within one access length of `REF_INTERVAL`.
- R9: `req_ready` is high only while the controller is idle with both strobes high. A request is taken only on a cycle with valid and ready both high, and each accepted request produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all actions on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address, row in [20:9], column in [8:0] |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `done` for a read |
| dram_addr | output | 12 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write line, low for write |
| dram_dq_out | output | 8 | Data toward the device |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 8 | Data from the device |

## Verification
Two things can land in the same cycle: the refresh timer expiring, and a request being accepted or an access being under way. The bench provokes this by issuing a long series of accesses across several refresh periods, so the timer expires during every phase of an access. It also keeps a request waiting at the moment an access ends, so a due refresh and a valid request meet in the idle state. The result is judged at the device pins. The refresh rows must run in sequence. The spacing between refreshes must stay within one access length of the interval. Every accepted access must still finish with correct latency, address and data.

// File: rtl/dmc_pkg.sv
// Package: shared state and select types for the multiplexed DRAM controller.
package dmc_pkg;

    // Sequencer phases; one access walks ROW_SETUP..PRECHARGE, a refresh
    // walks REF_SETUP, REF_HOLD, PRECHARGE.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ROW_SETUP = 3'd1,
        ST_RAS_WAIT  = 3'd2,
        ST_COL_SETUP = 3'd3,
        ST_CAS_HOLD  = 3'd4,
        ST_PRECHARGE = 3'd5,
        ST_REF_SETUP = 3'd6,
        ST_REF_HOLD  = 3'd7
    } dmc_state_e;

    // Which address half drives the shared pins.
    typedef enum logic {
        SEL_ROW = 1'b0,
        SEL_COL = 1'b1
    } dmc_addr_sel_e;

endpackage

// File: rtl/dmc_phase_timer.sv
// Module: dmc_phase_timer
// Down-counter that times one sequencer phase. Loading N-1 makes the phase
// last N cycles; expired is high while the count is zero.
// Assumes: load values fit in W bits; the counter rests at zero.
module dmc_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Count down to zero, or restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dmc_refresh_gen.sv
// Module: dmc_refresh_gen
// Free-running refresh timer plus refresh row counter. Raises pending once
// per INTERVAL cycles and holds it until the sequencer acknowledges; the row
// counter advances on each acknowledge and wraps at 2**ROW_W.
// Assumes: INTERVAL >= 2; a tick that arrives while pending is already set
// merges with it.
module dmc_refresh_gen #(
    parameter int INTERVAL = 1560,
    parameter int ROW_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    localparam int TW = $clog2(INTERVAL);
    localparam logic [TW-1:0] TICK_LAST = TW'(INTERVAL - 1);

    logic [TW-1:0]    tick_q;
    logic             pend_q;
    logic [ROW_W-1:0] row_q;
    logic             tick_wrap;

    assign tick_wrap = (tick_q == TICK_LAST);

    // Interval counter, restarting at zero after each full period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_wrap) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Pending flag: set by a period wrap, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (tick_wrap) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    // Row counter: steps once per refresh taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (ack) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign pending = pend_q;
    assign row     = row_q;

endmodule

// File: rtl/dmc_addr_mux.sv
// Module: dmc_addr_mux
// Places either the row or the column half on the shared address pins. The
// column is zero-extended onto the low pins when it is narrower than the row.
// Assumes: COL_W <= ROW_W.
module dmc_addr_mux
    import dmc_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 9
) (
    input  dmc_addr_sel_e    sel,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] pins
);

    logic [ROW_W-1:0] col_ext;

    generate
        if (COL_W < ROW_W) begin : g_pad
            assign col_ext = {{(ROW_W - COL_W){1'b0}}, col};
        end else begin : g_full
            assign col_ext = col[ROW_W-1:0];
        end
    endgenerate

    // Choose the half that the current phase presents.
    always_comb begin
        pins = (sel == SEL_COL) ? col_ext : row;
    end

endmodule

// File: rtl/dmc_seq.sv
// Module: dmc_seq
// Strobe sequencer. From idle it starts either a refresh (first priority) or
// a request. An access runs: row setup, row strobe low, column setup, column
// strobe low, precharge. A refresh runs: row setup, row strobe low, precharge.
// Phase lengths come from T_ADDR, T_STROBE and T_PRE.
// Assumes: all timing parameters >= 1; the device drives read data while the
// column strobe is low.
module dmc_seq
    import dmc_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int COL_W    = 9,
    parameter int DATA_W   = 8,
    parameter int T_ADDR   = 1,
    parameter int T_STROBE = 2,
    parameter int T_PRE    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    output logic                   done,
    output logic [DATA_W-1:0]      rdata,
    input  logic                   ref_pending,
    input  logic [ROW_W-1:0]       ref_row,
    output logic                   ref_ack,
    output dmc_addr_sel_e          addr_sel,
    output logic [ROW_W-1:0]       row_out,
    output logic [COL_W-1:0]       col_out,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    input  logic [DATA_W-1:0]      dq_in
);

    localparam int ADDR_W = ROW_W + COL_W;
    localparam int T_MAX0 = (T_ADDR > T_STROBE) ? T_ADDR : T_STROBE;
    localparam int T_MAX  = (T_MAX0 > T_PRE) ? T_MAX0 : T_PRE;
    localparam int CW     = (T_MAX > 1) ? $clog2(T_MAX) : 1;
    localparam logic [CW-1:0] LD_ADDR   = CW'(T_ADDR - 1);
    localparam logic [CW-1:0] LD_STROBE = CW'(T_STROBE - 1);
    localparam logic [CW-1:0] LD_PRE    = CW'(T_PRE - 1);

    dmc_state_e          state_q, state_d;
    logic [ROW_W-1:0]    row_q;
    logic [COL_W-1:0]    col_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                done_q;
    logic                t_load;
    logic [CW-1:0]       t_val;
    logic                t_exp;
    logic                accept;
    logic                take_ref;
    logic                cas_end;

    dmc_phase_timer #(.W(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    // Idle arbitration: a pending refresh wins over a waiting request.
    assign take_ref  = (state_q == ST_IDLE) && ref_pending;
    assign req_ready = (state_q == ST_IDLE) && !ref_pending;
    assign accept    = req_ready && req_valid;
    assign ref_ack   = take_ref;
    assign cas_end   = (state_q == ST_CAS_HOLD) && t_exp;

    // Next phase and the timer load for the phase being entered.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_ref) begin
                    state_d = ST_REF_SETUP;
                    t_load  = 1'b1;
                    t_val   = LD_ADDR;
                end else if (accept) begin
                    state_d = ST_ROW_SETUP;
                    t_load  = 1'b1;
                    t_val   = LD_ADDR;
                end
            end
            ST_ROW_SETUP: if (t_exp) begin
                state_d = ST_RAS_WAIT;
                t_load  = 1'b1;
                t_val   = LD_STROBE;
            end
            ST_RAS_WAIT: if (t_exp) begin
                state_d = ST_COL_SETUP;
                t_load  = 1'b1;
                t_val   = LD_ADDR;
            end
            ST_COL_SETUP: if (t_exp) begin
                state_d = ST_CAS_HOLD;
                t_load  = 1'b1;
                t_val   = LD_STROBE;
            end
            ST_CAS_HOLD: if (t_exp) begin
                state_d = ST_PRECHARGE;
                t_load  = 1'b1;
                t_val   = LD_PRE;
            end
            ST_REF_SETUP: if (t_exp) begin
                state_d = ST_REF_HOLD;
                t_load  = 1'b1;
                t_val   = LD_STROBE;
            end
            ST_REF_HOLD: if (t_exp) begin
                state_d = ST_PRECHARGE;
                t_load  = 1'b1;
                t_val   = LD_PRE;
            end
            ST_PRECHARGE: if (t_exp) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the request, or the refresh row, as a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (take_ref) begin
            row_q   <= ref_row;
            we_q    <= 1'b0;
        end else if (accept) begin
            row_q   <= req_addr[ADDR_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end
    end

    // Read capture and completion pulse at the end of the column phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= cas_end;
            if (cas_end && !we_q) begin
                rdata_q <= dq_in;
            end
        end
    end

    // Pin levels decoded from the registered phase.
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        dq_oe    = 1'b0;
        addr_sel = SEL_ROW;
        unique case (state_q)
            ST_RAS_WAIT:  ras_n = 1'b0;
            ST_REF_HOLD:  ras_n = 1'b0;
            ST_COL_SETUP: begin
                ras_n    = 1'b0;
                addr_sel = SEL_COL;
                we_n     = !we_q;
                dq_oe    = we_q;
            end
            ST_CAS_HOLD: begin
                ras_n    = 1'b0;
                cas_n    = 1'b0;
                addr_sel = SEL_COL;
                we_n     = !we_q;
                dq_oe    = we_q;
            end
            default: ;
        endcase
    end

    assign row_out = row_q;
    assign col_out = col_q;
    assign dq_out  = wdata_q;
    assign rdata   = rdata_q;
    assign done    = done_q;

endmodule

// File: rtl/dram_mux_ctrl.sv
// Module: dram_mux_ctrl (top)
// Controller for an asynchronous DRAM with row/column address multiplexing
// and a built-in periodic row refresh.
// Assumes: a single requester; the device latches addresses on the falling
// strobe edges; timing parameters >= 1 and COL_W <= ROW_W.
module dram_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_ADDR       = 1,
    parameter int T_STROBE     = 2,
    parameter int T_PRE        = 2,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   done,
    output logic [DATA_W-1:0]      rdata,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);

    logic             ref_pending;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;
    dmc_addr_sel_e    addr_sel;
    logic [ROW_W-1:0] row_cur;
    logic [COL_W-1:0] col_cur;

    dmc_refresh_gen #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W)
    ) refresh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    dmc_seq #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .DATA_W   (DATA_W),
        .T_ADDR   (T_ADDR),
        .T_STROBE (T_STROBE),
        .T_PRE    (T_PRE)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .done        (done),
        .rdata       (rdata),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_ack     (ref_ack),
        .addr_sel    (addr_sel),
        .row_out     (row_cur),
        .col_out     (col_cur),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .dq_in       (dram_dq_in)
    );

    dmc_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) mux_i (
        .sel  (addr_sel),
        .row  (row_cur),
        .col  (col_cur),
        .pins (dram_addr)
    );

endmodule

// File: rtl/dram_mux_ctrl_checker.sv
// Module: dram_mux_ctrl_checker
// Pin-level protocol properties of the controller, bound to the top module.
// Assumes: COL_W < ROW_W so that upper pins exist during the column phase.
module dram_mux_ctrl_checker #(
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    parameter int T_PRE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             done,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_dq_oe
);

    localparam logic [15:0] HI_MAX = 16'hFFFF;

    logic [15:0] hi_cnt;

    // Cycles the row strobe has been high; reset counts as fully precharged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 16'(T_PRE);
        end else if (!dram_ras_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_MAX) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_COL_UPPER_PINS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (dram_addr[ROW_W-1:COL_W] == '0)); // R2
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R3
    AST_ADDR_HELD_AT_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr)); // R3
    AST_ADDR_HELD_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(dram_cas_n)); // R4
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n); // R5
    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= 16'(T_PRE))); // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n)); // R9

endmodule

bind dram_mux_ctrl dram_mux_ctrl_checker #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .T_PRE (T_PRE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_oe (dram_dq_oe)
);

// File: tb/dram_mux_ctrl_tb_top.sv
// Bench: table-driven accesses, then a refresh-only phase and a long access
// stream across refresh periods. A behavioural device stub answers on the pins.
module dram_mux_ctrl_tb_top;

    localparam int T_ADDR   = 1;
    localparam int T_STROBE = 2;
    localparam int T_PRE    = 2;
    localparam int REF_INT  = 60;
    localparam int LAT      = 2 * T_ADDR + 2 * T_STROBE + 1;
    localparam int R2C      = T_ADDR + T_STROBE;
    localparam int NVEC     = 10;

    // {we, addr[20:0], wdata[7:0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 21'h1FFE05, 8'hA5},
        {1'b0, 21'h1FFE05, 8'h00},
        {1'b0, 21'h000000, 8'h00},
        {1'b1, 21'h00A3C7, 8'h3C},
        {1'b0, 21'h00A3C7, 8'h00},
        {1'b0, 21'h155555, 8'h00},
        {1'b1, 21'h0001FF, 8'h81},
        {1'b0, 21'h0001FF, 8'h00},
        {1'b0, 21'h1FFC00, 8'h00},
        {1'b0, 21'h1FFFFF, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [11:0] dram_addr;
    logic        dram_ras_n;
    logic        dram_cas_n;
    logic        dram_we_n;
    logic [7:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [7:0]  dram_dq_in;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    dram_mux_ctrl #(
        .T_ADDR       (T_ADDR),
        .T_STROBE     (T_STROBE),
        .T_PRE        (T_PRE),
        .REF_INTERVAL (REF_INT)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .done        (done),
        .rdata       (rdata),
        .dram_addr   (dram_addr),
        .dram_ras_n  (dram_ras_n),
        .dram_cas_n  (dram_cas_n),
        .dram_we_n   (dram_we_n),
        .dram_dq_out (dram_dq_out),
        .dram_dq_oe  (dram_dq_oe),
        .dram_dq_in  (dram_dq_in)
    );

    // ---------------- device stub ----------------
    int          cyc = 0;
    logic [7:0]  stub_mem [64];
    logic [7:0]  exp_mem  [64];
    logic [11:0] st_row = '0;
    logic [11:0] st_col = '0;
    logic        cas_seen = 1'b0;
    logic [11:0] acc_row = '0;
    logic [11:0] acc_col = '0;
    logic        acc_we = 1'b1;
    logic [7:0]  acc_wd = '0;
    logic        acc_oe = 1'b0;
    int          ras_fall_cyc = 0;
    int          ras_rise_cyc = -1;
    int          last_ref_fall = -1;
    int          r2c = 0;
    int          ref_seen = 0;
    int          ref_row_err = 0;
    int          exp_ref_row = 0;
    int          gap_err = 0;
    int          pre_err = 0;
    int          pre_cnt = 0;
    int          cas_no_ras = 0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            stub_mem[i] = 8'(i * 7 + 3);
            exp_mem[i]  = 8'(i * 7 + 3);
        end
    end

    always @(negedge clk) cyc <= cyc + 1;

    assign dram_dq_in = stub_mem[{st_row[2:0], st_col[2:0]}];

    always @(negedge dram_ras_n) begin
        st_row = dram_addr;
        cas_seen = 1'b0;
        ras_fall_cyc = cyc;
        if (ras_rise_cyc >= 0) begin
            pre_cnt++;
            if (cyc - ras_rise_cyc < T_PRE + T_ADDR) pre_err++;
        end
    end

    always @(negedge dram_cas_n) begin
        st_col = dram_addr;
        cas_seen = 1'b1;
        if (dram_ras_n) cas_no_ras++;
        acc_row = st_row;
        acc_col = dram_addr;
        acc_we  = dram_we_n;
        acc_wd  = dram_dq_out;
        acc_oe  = dram_dq_oe;
        r2c     = cyc - ras_fall_cyc;
        if (!dram_we_n) stub_mem[{st_row[2:0], dram_addr[2:0]}] = dram_dq_out;
    end

    always @(posedge dram_ras_n) begin
        ras_rise_cyc = cyc;
        if (!cas_seen) begin
            if (st_row != 12'(exp_ref_row)) ref_row_err++;
            exp_ref_row = (exp_ref_row + 1) % 4096;
            if (last_ref_fall >= 0) begin
                if (ras_fall_cyc - last_ref_fall > REF_INT + 11 ||
                    ras_fall_cyc - last_ref_fall < REF_INT - 11) gap_err++;
            end
            last_ref_fall = ras_fall_cyc;
            ref_seen++;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_access(input logic we, input logic [20:0] addr, input logic [7:0] wd);
        int idx;
        int n;
        idx = {addr[11:9], addr[2:0]};
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = addr;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        check(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == LAT, "R4 done latency", n, LAT);
        check(acc_row == addr[20:9], "R2 row pins", int'(acc_row), int'(addr[20:9]));
        check(acc_col == {3'b000, addr[8:0]}, "R2 column pins", int'(acc_col), int'(addr[8:0]));
        check(r2c == R2C, "R3 row-to-column spacing", r2c, R2C);
        if (we) begin
            check(!acc_we && acc_oe && acc_wd == wd, "R5 write data on pins", int'(acc_wd), int'(wd));
            exp_mem[idx] = wd;
        end else begin
            check(acc_we && !acc_oe, "R5 read keeps write line high", int'(acc_we), 1);
            check(rdata == exp_mem[idx], "R4 read data", int'(rdata), int'(exp_mem[idx]));
        end
        @(negedge clk);
        check(!done, "R4 done single pulse", int'(done), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int ref_before;
        logic busy_seen;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dram_ras_n && dram_cas_n, "R1 strobes high", int'({dram_ras_n, dram_cas_n}), 3);
        check(dram_we_n && !dram_dq_oe, "R1 write line high, drivers off", int'(dram_dq_oe), 0);
        check(!done && req_ready, "R1 done low, ready high", int'({done, req_ready}), 1);

        // R7 first refresh with no traffic: RAS-only, row 0, ready low meanwhile
        busy_seen = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!dram_ras_n && !busy_seen) begin
                busy_seen = 1'b1;
                check(!req_ready && dram_cas_n, "R8 ready low during refresh", int'(req_ready), 0);
            end
        end
        check(ref_seen == 1, "R7 one refresh after one interval", ref_seen, 1);
        check(ref_row_err == 0, "R7 first refresh row zero", ref_row_err, 0);

        // table of accesses
        for (int v = 0; v < NVEC; v++) begin
            do_access(VEC[v][29], VEC[v][28:8], VEC[v][7:0]);
        end

        // R8 stream across refresh periods; each access must complete
        ref_before = ref_seen;
        for (int k = 0; k < 40; k++) begin
            do_access(k[0], 21'(k * 32'h0B7A3 + 32'h1234), 8'(k * 13 + 1));
        end
        check(ref_seen - ref_before >= 4, "R8 refreshes taken during traffic", ref_seen - ref_before, 4);
        check(gap_err == 0, "R8 refresh spacing bound", gap_err, 0);
        check(ref_row_err == 0, "R7 refresh rows sequential", ref_row_err, 0);
        check(pre_err == 0 && pre_cnt > 0, "R6 precharge gap", pre_err, 0);
        check(cas_no_ras == 0, "R3 column strobe only inside row strobe", cas_no_ras, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule